// File: doc/BRIEF.md
# Bank Activation Timing Gate

This block sits between a memory controller's command generator and a four-bank synchronous DRAM. Each cycle it takes at most one requested command: activate, read, write or precharge. The request carries a bank and a row. For every bank the block tracks whether a row is open and which row it is. A request whose spacing rules are not yet satisfied is stalled, and the requester keeps it on the inputs until it is granted. A request that makes no sense for the bank's current state is rejected at once with an error flag.

Three spacing rules are enforced. The first is the minimum interval between two activates to the same bank (row cycle). The second is the interval from an activate to the first read or write in that bank (activate-to-access). The third is the interval between activates to any two banks (bank-to-bank). Each rule is given in picoseconds together with the clock period in picoseconds. At elaboration it becomes a whole number of cycles, rounded up. A granted command appears on a registered command bus one cycle later.

Top module: `bank_timing_gate`

## Requirements
- R1: After reset all banks are closed, all spacing counters are clear, and the command bus shows idle (code 0, bank 0, row 0). An activate presented in the first cycle after reset is granted without stall.
- R2: A granted request appears on the command bus in the next cycle. Command codes are: 0 idle, 1 activate, 2 read, 3 write, 4 precharge. An activate carries its bank and its requested row.
- R3: A read or write to a closed bank raises req_err_o for that cycle, with neither grant nor stall. The command bus stays idle.
- R4: An activate to a bank that already has an open row raises req_err_o, with neither grant nor stall.
- R5: A read or write to an open bank is granted no earlier than ceil(TRCD_PS/CLK_PS) cycles after that bank's activate was granted. At the defaults this is 3 cycles. Later accesses to the same bank are not delayed again.
- R6: Two activates to any banks are granted at least ceil(TRRD_PS/CLK_PS) cycles apart. At the defaults the division is exact and gives 2 cycles.
- R7: Two activates to the same bank are granted at least ceil(TRC_PS/CLK_PS) cycles apart, even when a precharge closed the bank in between. At the defaults this is 9 cycles.
- R8: A precharge is granted in the cycle it is presented and closes the bank. A precharge to a bank that is already closed is granted and leaves the bank closed. The bus row field for a precharge is 0.
- R9: While a request is stalled, req_stall_o is high and req_grant_o is low. At most one of grant, stall and error is high in any cycle. The command bus is idle in every cycle that follows a cycle without a grant.
- R10: A granted read or write puts on the bus row field the row currently open in its bank. Each bank keeps its own open row, independent of activates to other banks.
- R11: A request with code 0 or an undefined code (5 to 7) is rejected with req_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_cmd_i | input | 3 | Requested command code |
| req_bank_i | input | 2 | Requested bank |
| req_row_i | input | 13 | Row for an activate |
| req_grant_o | output | 1 | Request accepted this cycle |
| req_stall_o | output | 1 | Request must be held; spacing not met |
| req_err_o | output | 1 | Request rejected as illegal |
| cmd_o | output | 3 | Issued command code, registered |
| cmd_bank_o | output | 2 | Issued bank |
| cmd_row_o | output | 13 | Issued row (activate row or open row) |

## Verification
Activates, reads, writes and precharges are sent back to back so that each spacing rule on its own decides how many stall cycles follow. The count of stall cycles then shows whether a counter starts at the grant edge and whether it rounds up: a row-cycle count that is one cycle off gives a different stall number than an exact-division bank-to-bank count. Sequences that open two banks with different rows and then access both show whether the row state is per bank or shared. Reads to closed banks, activates to open banks and undefined codes separate rejection from stalling.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // ns-style limit to whole cycles, rounded up
  function automatic int unsigned ceil_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  // counter preload so the next command lands exactly n cycles later
  function automatic int unsigned gap_load(input int unsigned n);
    return (n > 0) ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/gap_counter.sv
module gap_counter #(
  parameter int unsigned LOAD = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);
  localparam int unsigned W = (LOAD < 1) ? 1 : $clog2(LOAD + 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= W'(LOAD);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

  generate
    if (LOAD > 0) begin : g_chk
      // R5 R6 R7: a fresh load blocks the following cycle
      p_gap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> !zero_o);
      p_gap_drain_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!zero_o && !load_i) |=> $past(cnt_q) == cnt_q + 1'b1);
    end
  endgenerate

endmodule

// File: rtl/bank_state.sv
module bank_state #(
  parameter int unsigned ROW_W   = 13,
  parameter int unsigned RC_LD   = 8,
  parameter int unsigned RCD_LD  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             act_ok_o,
  output logic             acc_ok_o
);
  logic             open_q;
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (pre_i) begin
      open_q <= 1'b0;
    end
  end

  gap_counter #(.LOAD(RC_LD)) u_rc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (act_i),
    .zero_o (act_ok_o)
  );

  gap_counter #(.LOAD(RCD_LD)) u_rcd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (act_i),
    .zero_o (acc_ok_o)
  );

  assign open_o = open_q;
  assign row_o  = row_q;

  p_act_closed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_o);
  p_row_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (open_o && row_o == $past(row_i)));
  p_pre_close_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_i && !act_i) |=> !open_o);

endmodule

// File: rtl/bank_timing_gate.sv
module bank_timing_gate
  import bank_timing_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned CLK_PS    = 7500,
  parameter int unsigned TRC_PS    = 67000,
  parameter int unsigned TRCD_PS   = 19000,
  parameter int unsigned TRRD_PS   = 15000,
  localparam int unsigned BANK_W   = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_cmd_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  output logic              req_grant_o,
  output logic              req_stall_o,
  output logic              req_err_o,
  output logic [2:0]        cmd_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o
);
  localparam int unsigned RC_LD  = gap_load(ceil_cyc(TRC_PS,  CLK_PS));
  localparam int unsigned RCD_LD = gap_load(ceil_cyc(TRCD_PS, CLK_PS));
  localparam int unsigned RRD_LD = gap_load(ceil_cyc(TRRD_PS, CLK_PS));

  cmd_e req_cmd;
  assign req_cmd = cmd_e'(req_cmd_i);

  logic [NUM_BANKS-1:0] open_v, act_ok_v, acc_ok_v, act_sel, pre_sel;
  logic [ROW_W-1:0]     row_v [NUM_BANKS];
  logic                 rrd_ok, legal, ready;
  logic                 is_act, is_pre;

  assign is_act = req_grant_o && (req_cmd == CMD_ACT);
  assign is_pre = req_grant_o && (req_cmd == CMD_PRE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_sel[b] = is_act && (req_bank_i == BANK_W'(b));
    assign pre_sel[b] = is_pre && (req_bank_i == BANK_W'(b));

    bank_state #(
      .ROW_W  (ROW_W),
      .RC_LD  (RC_LD),
      .RCD_LD (RCD_LD)
    ) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_sel[b]),
      .pre_i    (pre_sel[b]),
      .row_i    (req_row_i),
      .open_o   (open_v[b]),
      .row_o    (row_v[b]),
      .act_ok_o (act_ok_v[b]),
      .acc_ok_o (acc_ok_v[b])
    );
  end

  gap_counter #(.LOAD(RRD_LD)) u_rrd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (is_act),
    .zero_o (rrd_ok)
  );

  always_comb begin
    legal = 1'b0;
    ready = 1'b0;
    unique case (req_cmd)
      CMD_ACT: begin
        legal = !open_v[req_bank_i];
        ready = act_ok_v[req_bank_i] && rrd_ok;
      end
      CMD_RD, CMD_WR: begin
        legal = open_v[req_bank_i];
        ready = acc_ok_v[req_bank_i];
      end
      CMD_PRE: begin
        legal = 1'b1;
        ready = 1'b1;
      end
      default: ;
    endcase
  end

  assign req_grant_o = req_valid_i && legal && ready;
  assign req_stall_o = req_valid_i && legal && !ready;
  assign req_err_o   = req_valid_i && !legal;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_row_o  <= '0;
    end else if (req_grant_o) begin
      cmd_o      <= req_cmd_i;
      cmd_bank_o <= req_bank_i;
      unique case (req_cmd)
        CMD_ACT:        cmd_row_o <= req_row_i;
        CMD_RD, CMD_WR: cmd_row_o <= row_v[req_bank_i];
        default:        cmd_row_o <= '0;
      endcase
    end else begin
      cmd_o      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_row_o  <= '0;
    end
  end

  p_one_outcome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_grant_o, req_stall_o, req_err_o}));
  p_bus_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_grant_o |=> cmd_o == CMD_NOP);
  p_bus_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_grant_o |=> (cmd_o == $past(req_cmd_i) && cmd_bank_o == $past(req_bank_i)));

  generate
    if (RRD_LD > 0) begin : g_rrd_chk
      p_act_spacing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        is_act |=> !is_act);
    end
  endgenerate

endmodule

// File: tb/bank_timing_gate_bench.sv
module bank_timing_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned CLK_PS  = 7500;
  localparam int unsigned TRC_PS  = 67000;
  localparam int unsigned TRCD_PS = 19000;
  localparam int unsigned TRRD_PS = 15000;
  localparam int N_RC  = (TRC_PS  + CLK_PS - 1) / CLK_PS;
  localparam int N_RCD = (TRCD_PS + CLK_PS - 1) / CLK_PS;
  localparam int N_RRD = (TRRD_PS + CLK_PS - 1) / CLK_PS;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic grant, stall, err;
  logic [2:0] cmd_o;
  logic [1:0] cmd_bank;
  logic [12:0] cmd_row;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_timing_gate #(
    .CLK_PS(CLK_PS), .TRC_PS(TRC_PS), .TRCD_PS(TRCD_PS), .TRRD_PS(TRRD_PS)
  ) u_bank_timing_gate (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .req_bank_i(req_bank), .req_row_i(req_row), .req_grant_o(grant),
    .req_stall_o(stall), .req_err_o(err), .cmd_o(cmd_o), .cmd_bank_o(cmd_bank),
    .cmd_row_o(cmd_row)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    req_valid = 1'b0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // presents a request at the current falling edge, holds it until granted
  task automatic send(input logic [2:0] c, input logic [1:0] b, input logic [12:0] r,
                      input int exp_stalls, input logic [12:0] exp_row, input string tag);
    int stalls = 0;
    req_valid = 1'b1; req_cmd = c; req_bank = b; req_row = r;
    forever begin
      #1;
      if (grant) break;
      check(stall && !err, {tag, " R9 stall flag"}, int'(stall), 1);
      if (stalls > 0) check(cmd_o == C_NOP, {tag, " R9 bus idle in stall"}, int'(cmd_o), 0);
      @(negedge clk);
      stalls++;
      if (stalls > 40) break;
    end
    check(stalls == exp_stalls, {tag, " stall cycles"}, stalls, exp_stalls);
    @(negedge clk);
    check(cmd_o == c, {tag, " R2 bus cmd"}, int'(cmd_o), int'(c));
    check(cmd_bank == b, {tag, " R2 bus bank"}, int'(cmd_bank), int'(b));
    check(cmd_row == exp_row, {tag, " bus row"}, int'(cmd_row), int'(exp_row));
    req_valid = 1'b0;
  endtask

  task automatic reject(input logic [2:0] c, input logic [1:0] b, input string tag);
    req_valid = 1'b1; req_cmd = c; req_bank = b; req_row = 13'h0123;
    #1;
    check(err && !grant && !stall, {tag, " error flag"}, int'({grant, stall, err}), 1);
    @(negedge clk);
    check(cmd_o == C_NOP, {tag, " bus idle after reject"}, int'(cmd_o), 0);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(cmd_o == C_NOP && cmd_bank == 0 && cmd_row == 0, "R1 bus idle", int'(cmd_o), 0);
    check(!grant && !stall && !err, "R1 no outcome", int'({grant, stall, err}), 0);
    @(negedge clk);
    send(C_ACT, 2'd2, 13'd5, 0, 13'd5, "R1 first act");
  endtask

  task automatic t_closed_access();
    do_reset();
    reject(C_RD, 2'd0, "R3 read closed");
    reject(C_WR, 2'd3, "R3 write closed");
  endtask

  task automatic t_double_act();
    do_reset();
    send(C_ACT, 2'd1, 13'h0040, 0, 13'h0040, "R4 setup");
    idle(12);
    reject(C_ACT, 2'd1, "R4 act open bank");
  endtask

  task automatic t_rcd();
    do_reset();
    send(C_ACT, 2'd0, 13'h1ABC, 0, 13'h1ABC, "R5 act");
    send(C_RD, 2'd0, 13'h0, N_RCD - 1, 13'h1ABC, "R5 read after act");
    send(C_WR, 2'd0, 13'h0, 0, 13'h1ABC, "R5 second access");
  endtask

  task automatic t_rrd();
    do_reset();
    send(C_ACT, 2'd0, 13'd11, 0, 13'd11, "R6 act b0");
    send(C_ACT, 2'd1, 13'd22, N_RRD - 1, 13'd22, "R6 act b1");
    send(C_ACT, 2'd2, 13'd33, N_RRD - 1, 13'd33, "R6 act b2");
  endtask

  task automatic t_rc();
    do_reset();
    send(C_ACT, 2'd3, 13'd7, 0, 13'd7, "R7 act");
    send(C_PRE, 2'd3, 13'd0, 0, 13'd0, "R7 pre");
    send(C_ACT, 2'd3, 13'd9, N_RC - 2, 13'd9, "R7 re-act");
  endtask

  task automatic t_pre();
    do_reset();
    send(C_PRE, 2'd1, 13'd0, 0, 13'd0, "R8 pre closed");
    reject(C_RD, 2'd1, "R8 still closed");
    send(C_ACT, 2'd1, 13'd300, 0, 13'd300, "R8 act");
    idle(4);
    send(C_PRE, 2'd1, 13'd77, 0, 13'd0, "R8 pre open");
    reject(C_WR, 2'd1, "R8 closed after pre");
  endtask

  task automatic t_rows();
    do_reset();
    send(C_ACT, 2'd0, 13'h0AAA, 0, 13'h0AAA, "R10 act b0");
    send(C_ACT, 2'd1, 13'h1555, N_RRD - 1, 13'h1555, "R10 act b1");
    idle(5);
    send(C_RD, 2'd0, 13'h0, 0, 13'h0AAA, "R10 read b0");
    send(C_WR, 2'd1, 13'h0, 0, 13'h1555, "R10 write b1");
    send(C_RD, 2'd0, 13'h0, 0, 13'h0AAA, "R10 read b0 again");
  endtask

  task automatic t_badcode();
    do_reset();
    reject(C_NOP, 2'd0, "R11 idle code");
    reject(3'd6, 2'd2, "R11 undefined code");
  endtask

  initial begin
    t_reset();
    t_closed_access();
    t_double_act();
    t_rcd();
    t_rrd();
    t_rc();
    t_pre();
    t_rows();
    t_badcode();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule